// File: doc/BRIEF.md
# Successive Approximation Conversion Controller

This block is the digital sequencer of a successive approximation analog-to-digital converter. A start pulse does two things. It raises a sample-and-hold strobe in the same cycle, so the external analog stage freezes its input. It also loads the trial code with midscale. The trial code drives an external DAC. A one-bit comparator reports whether the held input lies above the DAC output.

On each following clock edge the controller settles one bit, working from the MSB down. It keeps or clears the bit under test, then raises the next lower bit for trial. After the LSB is decided, the trial code is the conversion result. An end-of-conversion flag rises and holds until the next start. A start that arrives at any time abandons the current search and begins a new one.

The analog parts are outside the block. The code width is a parameter with a default of 4.

Top module: `sar_search_ctrl`

## Requirements
- R1: A start sampled at a rising edge loads the code with midscale (only the MSB set, 4'b1000 by default) and clears the done flag. The hold strobe is high during the same cycle that start is high and reset is low.
- R2: During a conversion, if the comparator input is 1 at a decision edge, the bit under test stays 1.
- R3: During a conversion, if the comparator input is 0 at a decision edge, the bit under test is cleared. An input equal to the DAC value gives 0, so the bit is cleared.
- R4: Bits are decided from MSB to LSB. At each decision edge that is not the last, the next lower bit is set to 1 for trial.
- R5: The done flag stays low for the first WIDTH-1 edges after the start edge and rises on the WIDTH-th edge. At that point the code holds the result.
- R6: After completion and until the next start, clock edges leave the code and the done flag unchanged, whatever the comparator shows.
- R7: A start that arrives while a conversion is in progress restarts the search from midscale. The new conversion completes WIDTH edges later.
- R8: A synchronous active-high reset clears the code and the done flag and leaves the block idle. Reset takes priority over start, and the hold strobe is low while reset is high.
- R9: While idle after reset, with no start, the comparator input has no effect on the code or the done flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin (or restart) a conversion |
| cmp_above | input | 1 | 1 when the held input is strictly above the DAC output |
| hold_strobe | output | 1 | Sample-and-hold capture strobe |
| code | output | WIDTH | Trial code to the DAC; the result once done is high |
| eoc | output | 1 | End-of-conversion flag |

## Verification
The bench models the comparator as a strict integer comparison. Under this model an input equal to a trial value must clear its bit, so inputs 8 and 11 settle at 7 and 10. A design that kept bits on equality would return 8 and 11. The bench traces every intermediate trial code for one input, which catches a wrong bit order or a next trial bit that is never raised. It counts the edges to the done flag, which catches a done flag one cycle early or late. It restarts the block mid-search, asserts start under reset, and changes the analog input after sampling. A design that ignored restarts would finish with a stale code, and one that resampled the input would drift.

// File: rtl/sar_search_ctrl.sv
module sar_search_ctrl #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             cmp_above,
  output logic             hold_strobe,
  output logic [WIDTH-1:0] code,
  output logic             eoc
);
  localparam int PW = (WIDTH > 1) ? $clog2(WIDTH) : 1;
  localparam logic [WIDTH-1:0] MID = WIDTH'(1) << (WIDTH - 1);
  localparam logic [PW-1:0] TOP = PW'(WIDTH - 1);

  logic [PW-1:0] ptr;
  logic          busy;
  logic          last;

  assign last        = (ptr == '0);
  assign hold_strobe = start & ~rst;

  always_ff @(posedge clk) begin
    if (rst) begin
      code <= '0;
      ptr  <= '0;
      busy <= 1'b0;
      eoc  <= 1'b0;
    end else if (start) begin
      code <= MID;
      ptr  <= TOP;
      busy <= 1'b1;
      eoc  <= 1'b0;
    end else if (busy) begin
      code[ptr] <= cmp_above;
      if (!last) begin
        code[ptr - 1'b1] <= 1'b1;
        ptr <= ptr - 1'b1;
      end else begin
        busy <= 1'b0;
        eoc  <= 1'b1;
      end
    end
  end

  assert_start_mid_R1: assert property (@(posedge clk) disable iff (rst)
    start |=> (code == MID) && !eoc);

  assert_keep_bit_R2: assert property (@(posedge clk) disable iff (rst)
    (busy && !start && cmp_above) |=> code[$past(ptr)]);

  assert_clear_bit_R3: assert property (@(posedge clk) disable iff (rst)
    (busy && !start && !cmp_above) |=> !code[$past(ptr)]);

  assert_done_rise_R5: assert property (@(posedge clk) disable iff (rst)
    (busy && last && !start) |=> eoc);

  assert_done_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (eoc && !start) |=> eoc && $stable(code));

  assert_reset_clear_R8: assert property (@(posedge clk)
    rst |=> (code == '0) && !eoc);
endmodule

// File: tb/sim_sar_search_ctrl.sv
`timescale 1ns/1ps
module sim_sar_search_ctrl;
  localparam int W = 4;
  localparam int NV = 8;
  localparam int VEC_IN  [NV] = '{0, 1, 8, 9, 11, 15, 16, 5};
  localparam int VEC_OUT [NV] = '{0, 0, 7, 8, 10, 14, 15, 4};

  logic clk = 0, rst = 1, start = 0;
  logic hold_strobe, eoc;
  logic [W-1:0] code;
  int analog = 0, held = 0;
  logic cmp_above;
  int checks = 0, fails = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) if (hold_strobe) held <= analog;
  assign cmp_above = held > int'(code);

  sar_search_ctrl #(.WIDTH(W)) u0 (.clk(clk), .rst(rst), .start(start),
    .cmp_above(cmp_above), .hold_strobe(hold_strobe), .code(code), .eoc(eoc));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic begin_conv(input int s);
    @(negedge clk);
    analog = s; start = 1;
    #1 chk("R1 strobe", int'(hold_strobe), 1);
    @(negedge clk);
    start = 0;
    chk("R1 midscale", int'(code), 8);
    chk("R1 eoc low", int'(eoc), 0);
  endtask

  task automatic finish_conv(input int exp);
    for (int i = 1; i <= W; i++) begin
      @(negedge clk);
      chk("R5 eoc timing", int'(eoc), (i == W) ? 1 : 0);
    end
    chk("R2 R3 result", int'(code), exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    chk("R8 reset code", int'(code), 0);
    chk("R8 reset eoc", int'(eoc), 0);

    analog = 15;
    @(negedge clk) start = 0;
    held = 15;
    repeat (3) @(negedge clk);
    chk("R9 idle code", int'(code), 0);
    chk("R9 idle eoc", int'(eoc), 0);

    begin_conv(11);
    @(negedge clk) chk("R4 trace 1", int'(code), 12);
    @(negedge clk) chk("R4 trace 2", int'(code), 10);
    @(negedge clk) chk("R4 trace 3", int'(code), 11);
    @(negedge clk) chk("R4 trace 4", int'(code), 10);
    chk("R5 done", int'(eoc), 1);

    for (int v = 0; v < NV; v++) begin
      begin_conv(VEC_IN[v]);
      finish_conv(VEC_OUT[v]);
      analog = 15 - VEC_IN[v];
      repeat (3) @(negedge clk);
      chk("R6 code held", int'(code), VEC_OUT[v]);
      chk("R6 eoc held", int'(eoc), 1);
    end

    begin_conv(15);
    repeat (2) @(negedge clk);
    chk("R7 mid eoc", int'(eoc), 0);
    begin_conv(2);
    finish_conv(1);

    begin_conv(5);
    analog = 15;
    repeat (W - 1) @(negedge clk);
    chk("R1 held input eoc", int'(eoc), 0);
    @(negedge clk);
    chk("R1 held input result", int'(code), 4);

    begin_conv(13);
    @(negedge clk);
    rst = 1; start = 1;
    #1 chk("R8 strobe under reset", int'(hold_strobe), 0);
    @(negedge clk);
    rst = 0; start = 0;
    chk("R8 reset wins code", int'(code), 0);
    chk("R8 reset wins eoc", int'(eoc), 0);
    repeat (2) @(negedge clk);
    chk("R9 idle after reset", int'(code), 0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule